// File: doc/BRIEF.md
# Passive Cooling Throttle Level Calculator

This block works out how hard a processor clock should be throttled to keep the die near a target temperature. On each sample strobe it takes the present temperature reading, the target temperature and two coefficients. It forms a correction with two terms. One weights how fast the temperature is climbing, measured against the previously sampled reading. The other weights how far the reading sits from the target. The negated correction is truncated toward zero to a whole number of throttle steps and added to the current level.

The level is kept in eighths of full speed and held inside 12.5% to 100%. It is reported both as a step count and as a percentage in half-percent units. The block stores the previous reading and the current level itself. A caller only has to present a sample with a one-cycle strobe and pick up the result when the valid pulse appears three cycles later. Sensing the temperature and gating the clock are left to neighbouring logic.

Top module: `thr_throttle`

## Requirements
- R1: After reset `perf_step` is 8 (100%), `perf_pct` is 200 and `out_vld` is low.
- R2: For a sample strobe seen at clock edge k, `out_vld` is high for exactly one cycle, after edge k+2. It never rises without a strobe.
- R3: Temperatures are signed 12-bit values in 1/16 °C. Coefficients are unsigned 8-bit values in 1/16 % per °C. The correction is P = k_rate·(T − Tprev) + k_err·(T − Ttarget), expressed in 1/256 %. The new step count is the old step count plus the negation of P/3200, where 3200 units equal one 12.5% step.
- R4: The first sample after reset uses a zero rate term, because the previous reading is taken to equal that first sample.
- R5: The division by one step truncates toward zero for both positive and negative corrections. A correction smaller than one step leaves the level unchanged.
- R6: The step count never exceeds 8 (100%), however cold the reading.
- R7: The step count never drops below 1 (12.5%), however hot the reading.
- R8: Without a strobe, input changes have no effect. The level holds, and the stored previous reading is not replaced.
- R9: `perf_pct` always equals 25 times `perf_step`, in half-percent units.
- R10: Every strobed sample becomes the previous reading for the next rate term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_vld | input | 1 | One-cycle strobe marking a new sample |
| temp_now | input | 12 | Current temperature, signed, 1/16 °C |
| temp_goal | input | 12 | Target temperature, signed, 1/16 °C |
| k_rate | input | 8 | Coefficient on temperature change, 1/16 %/°C |
| k_err | input | 8 | Coefficient on distance from target, 1/16 %/°C |
| out_vld | output | 1 | One-cycle pulse when a new level is posted |
| perf_step | output | 4 | Performance level in eighths of full speed (1..8) |
| perf_pct | output | 8 | Performance level in half-percent units (25..200) |

## Verification
The assertions check on every cycle that the step count stays within 1 to 8 and that a valid pulse follows each strobe after a fixed three-cycle delay. They also check that no pulse appears without a strobe and that the level moves only together with a pulse. The arithmetic can only be shown by the bench scenarios, which compare the posted level with a model of the correction. These cover the zero rate term on the first sample, truncation toward zero in both directions, both clamps, and the previous reading staying untouched while the strobe is low.

// File: rtl/thr_pkg.sv
// Package: shared constants for the throttle calculator.
// Assumes the percent scale is full speed = 200 half-percent units.
package thr_pkg;
    localparam int FULL_HALF_PCT = 200;

    // Half-percent units represented by one throttle step.
    function automatic int half_pct_per_step(input int steps);
        return FULL_HALF_PCT / steps;
    endfunction
endpackage

// File: rtl/thr_delta.sv
// Stage 1: registers the temperature differences and coefficients.
// Holds the previous sampled temperature. The first sample after reset
// yields a zero rate difference. Updates only when smp_vld is high.
module thr_delta #(
    parameter int TEMP_W = 12,
    parameter int COEF_W = 8,
    localparam int DIFF_W = TEMP_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_vld,
    input  logic signed [TEMP_W-1:0] temp_now,
    input  logic signed [TEMP_W-1:0] temp_goal,
    input  logic        [COEF_W-1:0] k_rate,
    input  logic        [COEF_W-1:0] k_err,
    output logic                     d_vld,
    output logic signed [DIFF_W-1:0] d_rate,
    output logic signed [DIFF_W-1:0] d_err,
    output logic        [COEF_W-1:0] k_rate_q,
    output logic        [COEF_W-1:0] k_err_q
);
    logic signed [TEMP_W-1:0] prev_q;
    logic                     seen_q;
    logic signed [DIFF_W-1:0] rate_c;
    logic signed [DIFF_W-1:0] err_c;

    // Form both differences at full width, with no overflow possible.
    always_comb begin
        rate_c = seen_q ? (DIFF_W'(temp_now) - DIFF_W'(prev_q)) : '0;
        err_c  = DIFF_W'(temp_now) - DIFF_W'(temp_goal);
    end

    // Capture the differences and coefficients, and remember the sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            seen_q   <= 1'b0;
            d_vld    <= 1'b0;
            d_rate   <= '0;
            d_err    <= '0;
            k_rate_q <= '0;
            k_err_q  <= '0;
        end else begin
            d_vld <= smp_vld;
            if (smp_vld) begin
                prev_q   <= temp_now;
                seen_q   <= 1'b1;
                d_rate   <= rate_c;
                d_err    <= err_c;
                k_rate_q <= k_rate;
                k_err_q  <= k_err;
            end
        end
    end
endmodule

// File: rtl/thr_correct.sv
// Stage 2: weighted sum of the two differences.
// The coefficients are unsigned. The result is in the combined
// fraction units of temperature times coefficient.
module thr_correct #(
    parameter int DIFF_W = 13,
    parameter int COEF_W = 8,
    localparam int PROD_W = DIFF_W + COEF_W + 1,
    localparam int CORR_W = PROD_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     d_vld,
    input  logic signed [DIFF_W-1:0] d_rate,
    input  logic signed [DIFF_W-1:0] d_err,
    input  logic        [COEF_W-1:0] k_rate_q,
    input  logic        [COEF_W-1:0] k_err_q,
    output logic                     c_vld,
    output logic signed [CORR_W-1:0] corr
);
    logic signed [PROD_W-1:0] p_rate;
    logic signed [PROD_W-1:0] p_err;

    // Signed products, with the coefficients zero-extended.
    always_comb begin
        p_rate = PROD_W'(d_rate) * PROD_W'($signed({1'b0, k_rate_q}));
        p_err  = PROD_W'(d_err)  * PROD_W'($signed({1'b0, k_err_q}));
    end

    // Register the sum together with its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_vld <= 1'b0;
            corr  <= '0;
        end else begin
            c_vld <= d_vld;
            if (d_vld) begin
                corr <= CORR_W'(p_rate) + CORR_W'(p_err);
            end
        end
    end
endmodule

// File: rtl/thr_level.sv
// Stage 3: turns the correction into a throttle step change and holds
// the level. The division by one step truncates toward zero. The result
// is clamped to 1..NUM_STEPS and reported as steps and half-percents.
module thr_level #(
    parameter int CORR_W    = 23,
    parameter int FRAC_BITS = 8,
    parameter int NUM_STEPS = 8,
    localparam int LVL_W = $clog2(NUM_STEPS + 1),
    localparam int PCT_W = $clog2(thr_pkg::FULL_HALF_PCT + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     c_vld,
    input  logic signed [CORR_W-1:0] corr,
    output logic                     out_vld,
    output logic        [LVL_W-1:0]  perf_step,
    output logic        [PCT_W-1:0]  perf_pct
);
    localparam logic signed [CORR_W-1:0] STEP_Q =
        CORR_W'((100 << FRAC_BITS) / NUM_STEPS);
    localparam logic signed [CORR_W-1:0] LO_Q = CORR_W'(1);
    localparam logic signed [CORR_W-1:0] HI_Q = CORR_W'(NUM_STEPS);
    localparam int HALF_PER_STEP = thr_pkg::half_pct_per_step(NUM_STEPS);

    logic signed [CORR_W-1:0] adj;
    logic signed [CORR_W-1:0] cand;
    logic        [LVL_W-1:0]  lvl_next;

    // Negated correction in whole steps, added to the level and clamped.
    always_comb begin
        adj  = -(corr / STEP_Q);
        cand = $signed({{(CORR_W-LVL_W){1'b0}}, perf_step}) + adj;
        if (cand < LO_Q) begin
            lvl_next = LVL_W'(1);
        end else if (cand > HI_Q) begin
            lvl_next = LVL_W'(NUM_STEPS);
        end else begin
            lvl_next = cand[LVL_W-1:0];
        end
    end

    // Hold the level, and post a new one with a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            perf_step <= LVL_W'(NUM_STEPS);
            perf_pct  <= PCT_W'(thr_pkg::FULL_HALF_PCT);
        end else begin
            out_vld <= c_vld;
            if (c_vld) begin
                perf_step <= lvl_next;
                perf_pct  <= PCT_W'(lvl_next) * PCT_W'(HALF_PER_STEP);
            end
        end
    end
endmodule

// File: rtl/thr_throttle.sv
// Top level: passive cooling throttle calculator built as a three-stage
// pipeline (differences, weighted sum, step update). Assumes sample_vld
// is a one-cycle strobe. The result appears three cycles later.
module thr_throttle #(
    parameter int TEMP_W    = 12,
    parameter int COEF_W    = 8,
    parameter int FRAC_BITS = 8,
    parameter int NUM_STEPS = 8,
    localparam int DIFF_W = TEMP_W + 1,
    localparam int CORR_W = DIFF_W + COEF_W + 2,
    localparam int LVL_W  = $clog2(NUM_STEPS + 1),
    localparam int PCT_W  = $clog2(thr_pkg::FULL_HALF_PCT + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_vld,
    input  logic signed [TEMP_W-1:0] temp_now,
    input  logic signed [TEMP_W-1:0] temp_goal,
    input  logic        [COEF_W-1:0] k_rate,
    input  logic        [COEF_W-1:0] k_err,
    output logic                     out_vld,
    output logic        [LVL_W-1:0]  perf_step,
    output logic        [PCT_W-1:0]  perf_pct
);
    logic                     d_vld;
    logic signed [DIFF_W-1:0] d_rate;
    logic signed [DIFF_W-1:0] d_err;
    logic        [COEF_W-1:0] k_rate_q;
    logic        [COEF_W-1:0] k_err_q;
    logic                     c_vld;
    logic signed [CORR_W-1:0] corr;

    thr_delta #(.TEMP_W(TEMP_W), .COEF_W(COEF_W)) u_delta (
        .clk(clk), .rst_n(rst_n), .smp_vld(sample_vld),
        .temp_now(temp_now), .temp_goal(temp_goal),
        .k_rate(k_rate), .k_err(k_err),
        .d_vld(d_vld), .d_rate(d_rate), .d_err(d_err),
        .k_rate_q(k_rate_q), .k_err_q(k_err_q)
    );

    thr_correct #(.DIFF_W(DIFF_W), .COEF_W(COEF_W)) u_correct (
        .clk(clk), .rst_n(rst_n), .d_vld(d_vld),
        .d_rate(d_rate), .d_err(d_err),
        .k_rate_q(k_rate_q), .k_err_q(k_err_q),
        .c_vld(c_vld), .corr(corr)
    );

    thr_level #(.CORR_W(CORR_W), .FRAC_BITS(FRAC_BITS), .NUM_STEPS(NUM_STEPS)) u_level (
        .clk(clk), .rst_n(rst_n), .c_vld(c_vld), .corr(corr),
        .out_vld(out_vld), .perf_step(perf_step), .perf_pct(perf_pct)
    );
endmodule

// File: rtl/thr_throttle_chk.sv
// Checker: properties on the throttle calculator ports, bound to the top.
module thr_throttle_chk #(
    parameter int NUM_STEPS = 8,
    parameter int LVL_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_vld,
    input logic             out_vld,
    input logic [LVL_W-1:0] perf_step
);
    // R6 R7
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perf_step >= LVL_W'(1)) && (perf_step <= LVL_W'(NUM_STEPS)));

    // R2
    vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> ##3 out_vld);

    // R2
    vld_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(sample_vld, 3));

    // R8
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> $stable(perf_step));
endmodule

bind thr_throttle thr_throttle_chk #(.NUM_STEPS(NUM_STEPS), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
    .out_vld(out_vld), .perf_step(perf_step)
);

// File: tb/thr_throttle_tb.sv
// Directed bench for thr_throttle, with a reference model of the level.
module thr_throttle_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_vld = 1'b0;
    logic signed [11:0] temp_now = '0;
    logic signed [11:0] temp_goal = '0;
    logic        [7:0] k_rate = '0;
    logic        [7:0] k_err = '0;
    logic              out_vld;
    logic        [3:0] perf_step;
    logic        [7:0] perf_pct;

    int n_chk = 0;
    int n_bad = 0;
    int m_prev = 0;
    bit m_seen = 1'b0;
    int m_lvl = 8;

    always #2.5 clk = ~clk;

    thr_throttle u_dut (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
        .temp_now(temp_now), .temp_goal(temp_goal),
        .k_rate(k_rate), .k_err(k_err),
        .out_vld(out_vld), .perf_step(perf_step), .perf_pct(perf_pct)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: %s got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Strobe one sample, follow the pipeline and compare with the model.
    task automatic do_sample(input string req, input int t, input int tg,
                             input int c1, input int c2);
        int p;
        int lv;
        p = c1 * (m_seen ? (t - m_prev) : 0) + c2 * (t - tg);
        lv = m_lvl - (p / 3200);
        if (lv < 1) lv = 1;
        if (lv > 8) lv = 8;
        m_lvl = lv;
        m_prev = t;
        m_seen = 1'b1;
        @(negedge clk);
        temp_now = 12'(t);
        temp_goal = 12'(tg);
        k_rate = 8'(c1);
        k_err = 8'(c2);
        sample_vld = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0;
        check("R2", "early out_vld +1", int'(out_vld), 0);
        @(negedge clk);
        check("R2", "early out_vld +2", int'(out_vld), 0);
        @(negedge clk);
        check("R2", "out_vld at +3", int'(out_vld), 1);
        check(req, "perf_step", int'(perf_step), lv);
        check("R9", "perf_pct", int'(perf_pct), lv * 25);
        @(negedge clk);
        check("R2", "pulse width", int'(out_vld), 0);
    endtask

    // R1: state right after reset.
    task automatic t_reset();
        check("R1", "reset perf_step", int'(perf_step), 8);
        check("R1", "reset perf_pct", int'(perf_pct), 200);
        check("R1", "reset out_vld", int'(out_vld), 0);
    endtask

    // R8: inputs changing without a strobe leave the level and prev reading alone.
    task automatic t_ignore();
        @(negedge clk);
        temp_now = 12'(1800);
        temp_goal = 12'(0);
        k_rate = 8'(255);
        k_err = 8'(255);
        repeat (6) begin
            @(negedge clk);
            check("R8", "out_vld idle", int'(out_vld), 0);
        end
        check("R8", "perf_step idle", int'(perf_step), 8);
        // R8 R10: the rate term must still use the last strobed reading (-1000)
        do_sample("R8", -920, -920, 160, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R4: first sample, large rate coefficient yet no rate term
        do_sample("R4", 960, 800, 200, 80);
        // R5: under one step of heating leaves level alone
        do_sample("R5", 960, 960, 0, 16);
        do_sample("R5", 960, 800, 0, 16);
        // R5: under one step of cooling also leaves level alone
        do_sample("R5", 640, 800, 0, 16);
        // R3: cooling raises level
        do_sample("R3", 640, 800, 0, 40);
        // R10: rate term from previous reading 640
        do_sample("R10", 720, 720, 160, 0);
        // R7: strong heating hits the floor
        do_sample("R7", 2000, 800, 0, 255);
        // R6: strong cooling hits the ceiling
        do_sample("R6", -1000, 800, 0, 255);
        t_ignore();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish got 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule